// File: doc/BRIEF.md
# Active-Matrix Greyscale Pixel Formatter

This block turns packed framebuffer bytes into the byte stream for a single-scan active-matrix greyscale panel. The panel takes two 4-bit pixels per byte on an 8-bit bus, and each byte is marked by a shift strobe. Source bytes arrive on a ready/valid stream, and the depth of each byte is set by a select input. A byte can hold eight 1-bit pixels, four 2-bit pixels or two 4-bit pixels, so it expands into four, two or one output bytes.

1-bit pixels are copied into all four code bits. 2-bit pixels are first doubled into a 4-bit value and then treated like 4-bit pixels. A 4-bit value is cut down to a 3-bit level, and the code's lowest bit stays zero. The dropped bit returns as temporal dither: on alternate frames the level moves up one step, and the step stops at the top code. Even and odd pixel columns use opposite frame phases.

The raster geometry does not depend on depth. Every line holds `BYTES_PER_LINE` output bytes (320 by default), and a one-cycle line strobe follows the last byte of each line. Every frame holds `LINES_PER_FRAME` lines (400 by default). The frame marker is high for the whole first line of each frame. Output bytes go out at the rate the source stream supplies them, so a stall only inserts idle cycles.

Top module: `amg_fmt`

## Requirements
- R1: Each line has exactly `BYTES_PER_LINE` cycles with `cl2` high. `pix_data` is valid in each of those cycles.
- R2: After the last byte of a line, `cl1` is high for exactly one cycle. `cl2` is low in that cycle, and the two strobes are never high together.
- R3: `flm` is high from the first byte of line 0 of each frame through that line's `cl1`, and low for every other line. A frame has `LINES_PER_FRAME` lines, and line 0 follows reset.
- R4: `depth_sel` encodes the depth: 00 is 1 bit, 01 is 2 bits, 10 is 4 bits. Pixel 0 of a source byte is in its most significant bits. Each output byte carries the even pixel in bits 7:4 and the odd pixel in bits 3:0.
- R5: In 1-bit mode, each pixel gives nibble 1111 when set and 0000 when clear, with no dither.
- R6: In 2-bit mode, code c becomes the value {c,c}, which then goes through the R7 mapping. For example, 01 gives 0100 or 0110, and 10 always gives 1010.
- R7: In 4-bit mode, value v gives the nibble {L,0} with L = v>>1. L rises by one when v is odd and the frame phase XOR the pixel parity is 1. The frame phase is 0 after reset and toggles every frame. The even pixel has parity 0.
- R8: The level saturates at 7, so 15 and the 2-bit code 11 always give 1110.
- R9: When `src_valid` drops between bytes, `cl2` stays low until data returns. The content and the count of the line's bytes do not change.
- R10: `depth_sel` = 11 behaves exactly as 4-bit mode.
- R11: During reset, `cl1` and `cl2` are low, while `flm` and `src_ready` are high.

FSM states: `ST_WAIT` waits for a source byte. `ST_SHIFT` emits output bytes. `ST_LINE` pulses the line strobe. The transitions are:
- WAIT→SHIFT when a byte is taken.
- SHIFT→SHIFT on a remaining sub-byte, or when the next byte is taken without a gap.
- SHIFT→WAIT when a source byte is used up and none is offered.
- SHIFT→LINE after the last byte of a line.
- LINE→WAIT always.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| depth_sel | input | 2 | Source depth, captured with each source byte |
| src_valid | input | 1 | Source byte offered |
| src_data | input | 8 | Packed source pixels |
| src_ready | output | 1 | Source byte accepted when high with `src_valid` |
| pix_data | output | 8 | Two 4-bit panel pixels |
| cl2 | output | 1 | Shift strobe, one per output byte |
| cl1 | output | 1 | Line strobe |
| flm | output | 1 | First-line marker |

## Verification
The hardest state to reach is the flipped dither phase, because it exists only after a whole frame of lines has completed. The bench shrinks the raster through parameters to eight bytes and four lines. It runs two frames, sends the same 4-bit ramp in both, and expects the nudged columns to swap from odd to even. A line with gaps in the source stream exercises the fall-through acceptance path against the stalled path.

// File: rtl/amg_pkg.sv
package amg_pkg;
    typedef enum logic [1:0] {
        DEPTH_1  = 2'b00,
        DEPTH_2  = 2'b01,
        DEPTH_4  = 2'b10,
        DEPTH_4X = 2'b11
    } depth_e;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_SHIFT,
        ST_LINE
    } fsm_e;
endpackage

// File: rtl/amg_nibble_map.sv
module amg_nibble_map (
    input  logic [3:0] lvl_in,
    input  logic       dither_en,
    input  logic       nudge,
    output logic [3:0] nib_out
);
    logic [2:0] level;

    always_comb begin
        level = lvl_in[3:1];
        if (lvl_in[0] && nudge && (level != 3'd7))
            level = level + 3'd1;
        nib_out = dither_en ? {level, 1'b0} : lvl_in;
    end
endmodule

// File: rtl/amg_byte_pack.sv
module amg_byte_pack
    import amg_pkg::*;
(
    input  logic [7:0] src,
    input  depth_e     depth,
    input  logic [1:0] sub,
    input  logic       phase,
    output logic [7:0] byte_out
);
    localparam int NIBBLES = 2;

    logic [7:0] shl_one;
    logic [7:0] shl_two;

    assign shl_one = src << {sub, 1'b0};
    assign shl_two = src << {sub[0], 2'b00};

    for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
        localparam int HI1 = 7 - g;
        localparam int HI2 = 7 - 2 * g;
        localparam int HI4 = 7 - 4 * g;
        logic [3:0] field;
        logic [3:0] mapped;

        always_comb begin
            unique case (depth)
                DEPTH_1: field = {4{shl_one[HI1]}};
                DEPTH_2: field = {2{shl_two[HI2 -: 2]}};
                default: field = src[HI4 -: 4];
            endcase
        end

        amg_nibble_map i_map (
            .lvl_in    (field),
            .dither_en (depth != DEPTH_1),
            .nudge     (phase ^ g[0]),
            .nib_out   (mapped)
        );

        assign byte_out[HI4 -: 4] = mapped;
    end
endmodule

// File: rtl/amg_raster.sv
module amg_raster #(
    parameter int BYTES_PER_LINE  = 320,
    parameter int LINES_PER_FRAME = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_step,
    input  logic line_step,
    output logic last_byte,
    output logic first_line,
    output logic frame_phase
);
    localparam int BW = $clog2(BYTES_PER_LINE);
    localparam int LW = $clog2(LINES_PER_FRAME);
    localparam logic [BW-1:0] BYTE_MAX = BW'(BYTES_PER_LINE - 1);
    localparam logic [LW-1:0] LINE_MAX = LW'(LINES_PER_FRAME - 1);

    logic [BW-1:0] byte_cnt;
    logic [LW-1:0] line_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_cnt    <= '0;
            line_cnt    <= '0;
            frame_phase <= 1'b0;
        end else begin
            if (byte_step)
                byte_cnt <= (byte_cnt == BYTE_MAX) ? '0 : byte_cnt + 1'b1;
            if (line_step) begin
                if (line_cnt == LINE_MAX) begin
                    line_cnt    <= '0;
                    frame_phase <= ~frame_phase;
                end else begin
                    line_cnt <= line_cnt + 1'b1;
                end
            end
        end
    end

    assign last_byte  = (byte_cnt == BYTE_MAX);
    assign first_line = (line_cnt == '0);
endmodule

// File: rtl/amg_fmt.sv
module amg_fmt
    import amg_pkg::*;
#(
    parameter int BYTES_PER_LINE  = 320,
    parameter int LINES_PER_FRAME = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] depth_sel,
    input  logic       src_valid,
    input  logic [7:0] src_data,
    output logic       src_ready,
    output logic [7:0] pix_data,
    output logic       cl2,
    output logic       cl1,
    output logic       flm
);
    fsm_e       state, state_nx;
    logic [7:0] src_q;
    depth_e     mode_q;
    logic [1:0] sub_q;
    logic       sub_last;
    logic       last_byte;
    logic       first_line;
    logic       frame_phase;
    logic       take;
    logic [7:0] packed_byte;

    always_comb begin
        unique case (mode_q)
            DEPTH_1: sub_last = (sub_q == 2'd3);
            DEPTH_2: sub_last = sub_q[0];
            default: sub_last = 1'b1;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT:  if (src_valid) state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (sub_last) begin
                    if (last_byte)      state_nx = ST_LINE;
                    else if (src_valid) state_nx = ST_SHIFT;
                    else                state_nx = ST_WAIT;
                end
            end
            ST_LINE:  state_nx = ST_WAIT;
            default:  state_nx = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_nx;
    end

    assign src_ready = (state == ST_WAIT) ||
                       ((state == ST_SHIFT) && sub_last && !last_byte);
    assign take = src_ready && src_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            mode_q <= DEPTH_4;
            sub_q  <= '0;
        end else if (take) begin
            src_q  <= src_data;
            mode_q <= depth_e'(depth_sel);
            sub_q  <= '0;
        end else if ((state == ST_SHIFT) && !sub_last) begin
            sub_q <= sub_q + 2'd1;
        end
    end

    amg_raster #(
        .BYTES_PER_LINE  (BYTES_PER_LINE),
        .LINES_PER_FRAME (LINES_PER_FRAME)
    ) i_raster (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_step   (cl2),
        .line_step   (cl1),
        .last_byte   (last_byte),
        .first_line  (first_line),
        .frame_phase (frame_phase)
    );

    amg_byte_pack i_pack (
        .src      (src_q),
        .depth    (mode_q),
        .sub      (sub_q),
        .phase    (frame_phase),
        .byte_out (packed_byte)
    );

    always_comb begin
        cl2      = (state == ST_SHIFT);
        cl1      = (state == ST_LINE);
        flm      = first_line;
        pix_data = packed_byte;
    end
endmodule

// File: rtl/amg_fmt_chk.sv
module amg_fmt_chk #(
    parameter int BYTES_PER_LINE = 320
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cl1,
    input logic       cl2,
    input logic       flm,
    input logic [7:0] pix_data,
    input logic [1:0] mode_q
);
    localparam int CW = $clog2(BYTES_PER_LINE + 1);

    logic [CW-1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   seen <= '0;
        else if (cl1) seen <= '0;
        else if (cl2) seen <= seen + 1'b1;
    end

    a_r2_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(cl1 && cl2));

    a_r2_cl1_single: assert property (@(posedge clk) disable iff (!rst_n)
        cl1 |=> !cl1);

    a_r1_line_len: assert property (@(posedge clk) disable iff (!rst_n)
        cl1 |-> (seen == CW'(BYTES_PER_LINE)));

    a_r3_flm_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cl1) |-> $stable(flm));

    a_r7_low_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cl2 && mode_q != 2'b00) |-> (!pix_data[4] && !pix_data[0]));

    a_r5_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (cl2 && mode_q == 2'b00) |->
            ((pix_data[7:4] == 4'h0 || pix_data[7:4] == 4'hF) &&
             (pix_data[3:0] == 4'h0 || pix_data[3:0] == 4'hF)));
endmodule

bind amg_fmt amg_fmt_chk #(
    .BYTES_PER_LINE (BYTES_PER_LINE)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cl1      (cl1),
    .cl2      (cl2),
    .flm      (flm),
    .pix_data (pix_data),
    .mode_q   (mode_q)
);

// File: tb/test_amg_fmt.sv
module test_amg_fmt;
    localparam int BPL = 8;
    localparam int LPF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] depth_sel = 2'b00;
    logic       src_valid = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic       src_ready;
    logic [7:0] pix_data;
    logic       cl2, cl1, flm;

    int checks = 0;
    int fails  = 0;

    logic [7:0] srcbuf [BPL];
    logic [7:0] cap    [BPL];
    logic       capflm [BPL];
    int ptr = 0;
    int last_len = 0;
    logic last_flm = 1'b0;
    int lines_seen = 0;
    int r2_bad = 0;
    logic prev_cl1 = 1'b0;

    always #2.5 clk = ~clk;

    amg_fmt #(
        .BYTES_PER_LINE  (BPL),
        .LINES_PER_FRAME (LPF)
    ) i_amg_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .depth_sel (depth_sel),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_ready (src_ready),
        .pix_data  (pix_data),
        .cl2       (cl2),
        .cl1       (cl1),
        .flm       (flm)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (cl1 && cl2) r2_bad++;
            if (cl1 && prev_cl1) r2_bad++;
            if (cl2 && ptr < BPL) begin
                cap[ptr] = pix_data;
                capflm[ptr] = flm;
            end
            if (cl2) ptr++;
            if (cl1) begin
                last_len = ptr;
                last_flm = flm;
                ptr = 0;
                lines_seen++;
            end
            prev_cl1 = cl1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_nib(input logic [1:0] m, input logic [3:0] v,
                                           input logic par, input logic ph);
        logic [2:0] lv;
        if (m == 2'b00) return v;
        lv = v[3:1];
        if (v[0] && (ph ^ par) && lv != 3'd7) lv = lv + 3'd1;
        return {lv, 1'b0};
    endfunction

    function automatic logic [7:0] exp_byte(input logic [1:0] m, input int k, input logic ph);
        logic [7:0] sb;
        logic [3:0] hi, lo;
        int s;
        if (m == 2'b00) begin
            sb = srcbuf[k / 4]; s = k % 4;
            hi = {4{sb[7 - 2 * s]}};
            lo = {4{sb[6 - 2 * s]}};
        end else if (m == 2'b01) begin
            sb = srcbuf[k / 2]; s = k % 2;
            hi = {2{sb[7 - 4 * s -: 2]}};
            lo = {2{sb[5 - 4 * s -: 2]}};
        end else begin
            sb = srcbuf[k];
            hi = sb[7:4];
            lo = sb[3:0];
        end
        return {exp_nib(m, hi, 1'b0, ph), exp_nib(m, lo, 1'b1, ph)};
    endfunction

    task automatic run_line(input logic [1:0] m, input int nsrc, input bit stall,
                            input string req);
        int line_no = lines_seen;
        logic ph = ((line_no / LPF) % 2) == 1;
        logic fl = (line_no % LPF) == 0;
        int flm_bad = 0;
        depth_sel = m;
        for (int i = 0; i < nsrc; i++) begin
            @(negedge clk);
            if (stall && (i % 2 == 1)) begin
                src_valid = 1'b0;
                @(negedge clk);
                @(negedge clk);
            end
            src_valid = 1'b1;
            src_data = srcbuf[i];
            while (!src_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        src_valid = 1'b0;
        while (lines_seen == line_no) @(negedge clk);
        check(stall ? "R9 line length" : "R1 line length", last_len, BPL);
        check("R2 strobe overlap or double line strobe", r2_bad, 0);
        check("R3 flm at line strobe", last_flm, fl);
        for (int k = 0; k < BPL; k++) begin
            check(req, cap[k], exp_byte(m, k, ph));
            if (capflm[k] != fl) flm_bad++;
        end
        check("R3 flm during line", flm_bad, 0);
    endtask

    task automatic t_reset();
        #1;
        check("R11 cl1 in reset", cl1, 0);
        check("R11 cl2 in reset", cl2, 0);
        check("R11 flm in reset", flm, 1);
        check("R11 src_ready in reset", src_ready, 1);
    endtask

    task automatic load_ramp();
        for (int i = 0; i < 8; i++) srcbuf[i] = 8'((2 * i) << 4 | (2 * i + 1));
    endtask

    task automatic t_depth1_first();
        srcbuf[0] = 8'hA5; srcbuf[1] = 8'h3C;
        run_line(2'b00, 2, 1'b0, "R5 R4 1-bit replication");
    endtask

    task automatic t_depth2_frame0();
        srcbuf[0] = 8'h1B; srcbuf[1] = 8'hE4; srcbuf[2] = 8'h55; srcbuf[3] = 8'hFF;
        run_line(2'b01, 4, 1'b0, "R6 R8 2-bit expansion phase 0");
    endtask

    task automatic t_depth4_frame0();
        load_ramp();
        run_line(2'b10, 8, 1'b0, "R7 R8 4-bit ramp phase 0");
    endtask

    task automatic t_stall();
        srcbuf[0] = 8'hF0; srcbuf[1] = 8'h0F; srcbuf[2] = 8'h87; srcbuf[3] = 8'h78;
        srcbuf[4] = 8'h99; srcbuf[5] = 8'h66; srcbuf[6] = 8'hE1; srcbuf[7] = 8'h1E;
        run_line(2'b10, 8, 1'b1, "R9 stalled stream content");
    endtask

    task automatic t_depth4_frame1();
        load_ramp();
        run_line(2'b10, 8, 1'b0, "R7 R3 4-bit ramp phase 1");
    endtask

    task automatic t_depth_code3();
        load_ramp();
        run_line(2'b11, 8, 1'b0, "R10 code 11 as 4-bit");
    endtask

    task automatic t_depth2_frame1();
        srcbuf[0] = 8'h1B; srcbuf[1] = 8'hE4; srcbuf[2] = 8'h55; srcbuf[3] = 8'hFF;
        run_line(2'b01, 4, 1'b1, "R6 2-bit expansion phase 1");
    endtask

    task automatic t_depth1_last();
        srcbuf[0] = 8'hFF; srcbuf[1] = 8'h00;
        run_line(2'b00, 2, 1'b0, "R5 1-bit no dither phase 1");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_depth1_first();
        t_depth2_frame0();
        t_depth4_frame0();
        t_stall();
        t_depth4_frame1();
        t_depth_code3();
        t_depth2_frame1();
        t_depth1_last();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule